// File: doc/BRIEF.md
# Four-Layer Raster Compositor

The block builds one output frame, pixel by pixel in raster order, by stacking up to four input layers over a generated constant-colour background. Each layer has an enable, a top-left placement and a size. The size is the size of the layer's input, because no scaling takes place. For every output coordinate the block works out which layers cover it. It asks each layer's source for the pixel at the layer-local coordinate. The source answers in the same cycle. The block then runs the result through a cascade of four alpha-blend stages.

The first stage receives the background as its destination. Each later stage takes the previous stage's result as its destination. Layer 0 is the source of the first stage, layer 1 of the second, and so on, so layer 3 ends up on top. The second stage does not take layer 1 directly. Its source comes from a separate bitwise raster-op unit whose destination operand is layer 1 and whose operation is fixed to "keep destination", so layer 1 arrives unchanged.

The frame size and all placements are captured at the first pixel of a frame. A change made during a frame applies from the next frame. The output is a pixel stream with a valid flag, a start-of-frame marker and an end-of-line marker. Inputs and output use the same 8:8:8:8 alpha-plus-three-channel pixel, with no conversion.

Top module: `layer_compositor`

## Requirements
- R1: The frame width and height used are the configured values clamped to the range 4..8190. Every output row therefore holds between 4 and 8190 pixels.
- R2: Pixels leave in raster order, one per issued coordinate. `out_sof` is high only on pixel (0,0). `out_eol` is high only on the last pixel of each row. Both markers are high only together with `out_valid`.
- R3: The stage-0 destination is `bg_color` inside the rectangle at (`bg_x`,`bg_y`) of size `bg_w` x `bg_h`. Outside that rectangle it is all-zero (transparent black).
- R4: An enabled stage with source alpha `sa` computes each colour channel as round((dst·(255−sa) + src·sa)/255). It computes alpha as round((dst_a·(255−sa) + 255·sa)/255). Rounding is half-up. Alpha is bits 31:24; the colour channels are bits 23:16, 15:8 and 7:0.
- R5: Layer i feeds stage i, and the stages are applied in the order 0,1,2,3. Where layers overlap, a higher-numbered layer blends over the lower ones.
- R6: The source of stage 1 is the output of the raster-op unit running its keep-destination operation with layer 1 as destination. The layer 1 pixel therefore reaches stage 1 bit for bit.
- R7: A stage whose layer enable is low passes its destination through unchanged. Any pixel value presented on that layer's port has no effect on the output.
- R8: At an output coordinate outside a layer's rectangle, that layer acts as a fully transparent source and leaves the pixel unchanged.
- R9: A layer's top-left position is clamped to lie inside the frame: x to width−1 and y to height−1.
- R10: Frame size, background and layer settings are sampled when pixel (0,0) is issued. A change made during a frame takes effect with the next frame.
- R11: For a covered coordinate, the block presents the query coordinate (x−left, y−top) on the layer's port. For an uncovered coordinate it presents zero.
- R12: With `stream_en` low, no coordinate is issued and the raster position holds. `out_valid` follows `stream_en` five cycles later, and the frame resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_en | input | 1 | Issue one output coordinate this cycle |
| frm_w | input | CW | Requested frame width |
| frm_h | input | CW | Requested frame height |
| bg_x | input | CW | Background rectangle left |
| bg_y | input | CW | Background rectangle top |
| bg_w | input | CW | Background rectangle width |
| bg_h | input | CW | Background rectangle height |
| bg_color | input | 32 | Background fill pixel |
| lyr_en | input | NL | Per-layer enable |
| lyr_x | input | NL·CW | Per-layer left position |
| lyr_y | input | NL·CW | Per-layer top position |
| lyr_w | input | NL·CW | Per-layer input width |
| lyr_h | input | NL·CW | Per-layer input height |
| lyr_qx | output | NL·CW | Per-layer local query column |
| lyr_qy | output | NL·CW | Per-layer local query row |
| lyr_pix | input | NL·32 | Per-layer pixel answering the query in the same cycle |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 32 | Composited pixel |
| out_sof | output | 1 | First pixel of frame |
| out_eol | output | 1 | Last pixel of row |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a frame. The frame must finish with the settings captured at its first pixel, and the following frame must switch to the new ones. The bench moves layer 0 at a chosen issue count inside a frame. It expects the old placement for the whole of that frame and the new placement in the frame after it. A second hard case is a clamp at the 8190 limit. The bench asks for a width one past the limit, places a layer at the largest encodable column, and checks that both the row length and the clamped column hold.

// File: rtl/comp_pkg.sv
package comp_pkg;

   localparam int CH_W  = 8;
   localparam int PIX_W = 4 * CH_W;

   typedef struct packed {
      logic [CH_W-1:0] a;
      logic [CH_W-1:0] c2;
      logic [CH_W-1:0] c1;
      logic [CH_W-1:0] c0;
   } pix_t;

   // bitwise raster operations; code values are the unit's encoding
   typedef enum logic [3:0] {
      LOP_KEEP     = 4'd0,
      LOP_AND      = 4'd1,
      LOP_SRC_NDST = 4'd2,
      LOP_SRC      = 4'd3,
      LOP_NSRC_DST = 4'd4,
      LOP_ZERO     = 4'd5,
      LOP_XOR      = 4'd6,
      LOP_OR       = 4'd7,
      LOP_NOR      = 4'd8,
      LOP_XNOR     = 4'd9,
      LOP_NDST     = 4'd10,
      LOP_SRC_ONDST= 4'd11,
      LOP_NSRC     = 4'd12,
      LOP_NSRC_ODST= 4'd13,
      LOP_NAND     = 4'd14,
      LOP_ONES     = 4'd15
   } lop_e;

   // round((d*(max-sa) + s*sa) / max), max = 2**CH_W-1, half-up rounding
   function automatic logic [CH_W-1:0] mix(input logic [CH_W-1:0] d,
                                           input logic [CH_W-1:0] s,
                                           input logic [CH_W-1:0] sa);
      logic [2*CH_W:0] acc;
      logic [2*CH_W:0] fold;
      logic [CH_W-1:0] inv;
      inv  = ~sa;
      acc  = (2*CH_W+1)'(d) * (2*CH_W+1)'(inv)
           + (2*CH_W+1)'(s) * (2*CH_W+1)'(sa)
           + (2*CH_W+1)'(1 << (CH_W-1));
      fold = (acc + (acc >> CH_W)) >> CH_W;
      return fold[CH_W-1:0];
   endfunction

endpackage

// File: rtl/comp_raster.sv
module comp_raster #(
   parameter int CW    = 13,
   parameter int CFG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [CW-1:0]    live_w,
   input  logic [CW-1:0]    live_h,
   input  logic [CFG_W-1:0] live_cfg,
   output logic [CFG_W-1:0] act_cfg,
   output logic [CW-1:0]    pos_x,
   output logic [CW-1:0]    pos_y,
   output logic             row_end,
   output logic             frm_start
);

   logic [CW-1:0]    hold_w, hold_h, act_w, act_h;
   logic [CFG_W-1:0] hold_cfg;

   // settings are taken from the live inputs only on the first pixel
   assign frm_start = (pos_x == '0) && (pos_y == '0);
   assign act_w     = frm_start ? live_w   : hold_w;
   assign act_h     = frm_start ? live_h   : hold_h;
   assign act_cfg   = frm_start ? live_cfg : hold_cfg;
   assign row_end   = (pos_x == act_w - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_x    <= '0;
         pos_y    <= '0;
         hold_w   <= '0;
         hold_h   <= '0;
         hold_cfg <= '0;
      end else if (adv) begin
         hold_w   <= act_w;
         hold_h   <= act_h;
         hold_cfg <= act_cfg;
         if (row_end) begin
            pos_x <= '0;
            pos_y <= (pos_y == act_h - CW'(1)) ? '0 : pos_y + CW'(1);
         end else begin
            pos_x <= pos_x + CW'(1);
         end
      end
   end

endmodule

// File: rtl/comp_cover.sv
module comp_cover #(
   parameter int CW = 13
) (
   input  logic          en,
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   input  logic [CW-1:0] rx,
   input  logic [CW-1:0] ry,
   input  logic [CW-1:0] rw,
   input  logic [CW-1:0] rh,
   output logic          hit
);

   logic [CW:0] x_lim, y_lim;

   assign x_lim = {1'b0, rx} + {1'b0, rw};
   assign y_lim = {1'b0, ry} + {1'b0, rh};
   assign hit   = en && (x >= rx) && (y >= ry)
                && ({1'b0, x} < x_lim) && ({1'b0, y} < y_lim);

endmodule

// File: rtl/comp_rop.sv
module comp_rop
   import comp_pkg::*;
(
   input  lop_e             op,
   input  logic [PIX_W-1:0] src,
   input  logic [PIX_W-1:0] dst,
   output logic [PIX_W-1:0] res
);

   always_comb begin
      case (op)
         LOP_KEEP:      res = dst;
         LOP_AND:       res = src & dst;
         LOP_SRC_NDST:  res = src & ~dst;
         LOP_SRC:       res = src;
         LOP_NSRC_DST:  res = ~src & dst;
         LOP_ZERO:      res = '0;
         LOP_XOR:       res = src ^ dst;
         LOP_OR:        res = src | dst;
         LOP_NOR:       res = ~(src | dst);
         LOP_XNOR:      res = ~(src ^ dst);
         LOP_NDST:      res = ~dst;
         LOP_SRC_ONDST: res = src | ~dst;
         LOP_NSRC:      res = ~src;
         LOP_NSRC_ODST: res = ~src | dst;
         LOP_NAND:      res = ~(src & dst);
         LOP_ONES:      res = '1;
         default:       res = dst;
      endcase
   end

endmodule

// File: rtl/comp_blend.sv
module comp_blend
   import comp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_valid,
   input  logic             i_sof,
   input  logic             i_eol,
   input  logic             i_byp,
   input  logic [PIX_W-1:0] i_dst,
   input  logic [PIX_W-1:0] i_src,
   output logic             o_valid,
   output logic             o_sof,
   output logic             o_eol,
   output logic [PIX_W-1:0] o_pix
);

   pix_t d, s, r;

   assign d = i_dst;
   assign s = i_src;

   always_comb begin
      r.a  = mix(d.a,  {CH_W{1'b1}}, s.a);
      r.c2 = mix(d.c2, s.c2, s.a);
      r.c1 = mix(d.c1, s.c1, s.a);
      r.c0 = mix(d.c0, s.c0, s.a);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_sof   <= 1'b0;
         o_eol   <= 1'b0;
         o_pix   <= '0;
      end else begin
         o_valid <= i_valid;
         o_sof   <= i_sof;
         o_eol   <= i_eol;
         o_pix   <= i_byp ? i_dst : r;
      end
   end

endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
   import comp_pkg::*;
#(
   parameter int NL      = 4,
   parameter int CW      = 13,
   parameter int MIN_DIM = 4,
   parameter int MAX_DIM = 8190
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stream_en,
   input  logic [CW-1:0]     frm_w,
   input  logic [CW-1:0]     frm_h,
   input  logic [CW-1:0]     bg_x,
   input  logic [CW-1:0]     bg_y,
   input  logic [CW-1:0]     bg_w,
   input  logic [CW-1:0]     bg_h,
   input  logic [PIX_W-1:0]  bg_color,
   input  logic [NL-1:0]     lyr_en,
   input  logic [NL*CW-1:0]  lyr_x,
   input  logic [NL*CW-1:0]  lyr_y,
   input  logic [NL*CW-1:0]  lyr_w,
   input  logic [NL*CW-1:0]  lyr_h,
   output logic [NL*CW-1:0]  lyr_qx,
   output logic [NL*CW-1:0]  lyr_qy,
   input  logic [NL*PIX_W-1:0] lyr_pix,
   output logic              out_valid,
   output logic [PIX_W-1:0]  out_pix,
   output logic              out_sof,
   output logic              out_eol
);

   localparam int CFG_W = 4*CW + PIX_W + NL*(1 + 4*CW);
   localparam logic [CW-1:0] DMIN = CW'(MIN_DIM);
   localparam logic [CW-1:0] DMAX = CW'(MAX_DIM);
   localparam lop_e STAGE1_OP = LOP_KEEP;

   if (NL < 2 || NL > 8) begin : g_bad_nl
      $error("layer count out of range");
   end
   if (MIN_DIM < 1 || MIN_DIM > MAX_DIM) begin : g_bad_min
      $error("minimum frame size invalid");
   end
   if (MAX_DIM >= (1 << CW)) begin : g_bad_max
      $error("maximum frame size exceeds coordinate width");
   end

   function automatic logic [CW-1:0] fit_dim(input logic [CW-1:0] v);
      if (v < DMIN) return DMIN;
      if (v > DMAX) return DMAX;
      return v;
   endfunction

   // ---------------- live settings, clamped ----------------
   logic [CW-1:0]    live_w, live_h;
   logic [NL*CW-1:0] lx_fit, ly_fit;
   logic [CFG_W-1:0] live_cfg, act_cfg;

   assign live_w = fit_dim(frm_w);
   assign live_h = fit_dim(frm_h);

   for (genvar i = 0; i < NL; i++) begin : g_fit
      assign lx_fit[i*CW +: CW] = (lyr_x[i*CW +: CW] > live_w - CW'(1))
                                ? live_w - CW'(1) : lyr_x[i*CW +: CW];
      assign ly_fit[i*CW +: CW] = (lyr_y[i*CW +: CW] > live_h - CW'(1))
                                ? live_h - CW'(1) : lyr_y[i*CW +: CW];
   end

   assign live_cfg = {bg_x, bg_y, bg_w, bg_h, bg_color,
                      lyr_en, lx_fit, ly_fit, lyr_w, lyr_h};

   // ---------------- raster position and frame capture ----------------
   logic [CW-1:0] px, py;
   logic          row_end, frm_start;

   comp_raster #(.CW(CW), .CFG_W(CFG_W)) u_raster (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (stream_en),
      .live_w   (live_w),
      .live_h   (live_h),
      .live_cfg (live_cfg),
      .act_cfg  (act_cfg),
      .pos_x    (px),
      .pos_y    (py),
      .row_end  (row_end),
      .frm_start(frm_start)
   );

   logic [CW-1:0]    a_bgx, a_bgy, a_bgw, a_bgh;
   logic [PIX_W-1:0] a_bgc;
   logic [NL-1:0]    a_en;
   logic [NL*CW-1:0] a_lx, a_ly, a_lw, a_lh;

   assign {a_bgx, a_bgy, a_bgw, a_bgh, a_bgc,
           a_en, a_lx, a_ly, a_lw, a_lh} = act_cfg;

   // ---------------- background source ----------------
   logic bg_hit;

   comp_cover #(.CW(CW)) u_bg_cov (
      .en (1'b1),
      .x  (px),
      .y  (py),
      .rx (a_bgx),
      .ry (a_bgy),
      .rw (a_bgw),
      .rh (a_bgh),
      .hit(bg_hit)
   );

   // ---------------- raster-op unit feeding stage 1 ----------------
   logic [PIX_W-1:0] lop_res;

   comp_rop u_lop (
      .op (STAGE1_OP),
      .src(lyr_pix[0 +: PIX_W]),
      .dst(lyr_pix[PIX_W +: PIX_W]),
      .res(lop_res)
   );

   // ---------------- first pipeline register ----------------
   logic             s1_valid, s1_sof, s1_eol;
   logic [PIX_W-1:0] s1_bg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_sof   <= 1'b0;
         s1_eol   <= 1'b0;
         s1_bg    <= '0;
      end else begin
         s1_valid <= stream_en;
         s1_sof   <= stream_en & frm_start;
         s1_eol   <= stream_en & row_end;
         s1_bg    <= bg_hit ? a_bgc : '0;
      end
   end

   // ---------------- blend cascade ----------------
   logic [NL:0]      st_valid, st_sof, st_eol;
   logic [PIX_W-1:0] st_pix [NL+1];

   assign st_valid[0] = s1_valid;
   assign st_sof[0]   = s1_sof;
   assign st_eol[0]   = s1_eol;
   assign st_pix[0]   = s1_bg;

   for (genvar i = 0; i < NL; i++) begin : g_lyr
      logic             hit;
      logic [PIX_W-1:0] src_raw;
      // {bypass, source pixel}, delayed i cycles to meet stage i
      logic [PIX_W:0]   line [i+1];

      comp_cover #(.CW(CW)) u_cov (
         .en (a_en[i]),
         .x  (px),
         .y  (py),
         .rx (a_lx[i*CW +: CW]),
         .ry (a_ly[i*CW +: CW]),
         .rw (a_lw[i*CW +: CW]),
         .rh (a_lh[i*CW +: CW]),
         .hit(hit)
      );

      assign lyr_qx[i*CW +: CW] = hit ? px - a_lx[i*CW +: CW] : '0;
      assign lyr_qy[i*CW +: CW] = hit ? py - a_ly[i*CW +: CW] : '0;

      if (i == 1) begin : g_via_lop
         assign src_raw = lop_res;
      end else begin : g_direct
         assign src_raw = lyr_pix[i*PIX_W +: PIX_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line[0] <= '0;
         else        line[0] <= {~a_en[i], (hit ? src_raw : '0)};
      end

      for (genvar d = 1; d <= i; d++) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line[d] <= '0;
            else        line[d] <= line[d-1];
         end
      end

      comp_blend u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .i_valid(st_valid[i]),
         .i_sof  (st_sof[i]),
         .i_eol  (st_eol[i]),
         .i_byp  (line[i][PIX_W]),
         .i_dst  (st_pix[i]),
         .i_src  (line[i][PIX_W-1:0]),
         .o_valid(st_valid[i+1]),
         .o_sof  (st_sof[i+1]),
         .o_eol  (st_eol[i+1]),
         .o_pix  (st_pix[i+1])
      );
   end

   assign out_valid = st_valid[NL];
   assign out_sof   = st_sof[NL];
   assign out_eol   = st_eol[NL];
   assign out_pix   = st_pix[NL];

endmodule

// File: rtl/comp_chk.sv
module comp_chk #(
   parameter int CW      = 13,
   parameter int MIN_DIM = 4,
   parameter int MAX_DIM = 8190
) (
   input logic clk,
   input logic rst_n,
   input logic stream_en,
   input logic out_valid,
   input logic out_sof,
   input logic out_eol
);

   logic [CW:0] col;
   logic [2:0]  age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
         age <= '0;
      end else begin
         if (age != 3'd7) age <= age + 3'd1;
         if (out_valid) col <= out_eol ? '0 : col + (CW+1)'(1);
      end
   end

   // R2
   sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   // R2
   eol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eol |-> out_valid);

   // R2
   sof_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sof) |-> (col == '0));

   // R1
   row_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_eol) |-> ((col >= (CW+1)'(MIN_DIM-1))
                                  && (col <= (CW+1)'(MAX_DIM-1))));

   // R12
   valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd5) |-> (out_valid == $past(stream_en, 5)));

endmodule

bind layer_compositor comp_chk #(
   .CW     (CW),
   .MIN_DIM(MIN_DIM),
   .MAX_DIM(MAX_DIM)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .stream_en(stream_en),
   .out_valid(out_valid),
   .out_sof  (out_sof),
   .out_eol  (out_eol)
);

// File: tb/tb_layer_compositor.sv
`timescale 1ns/1ps
module tb_layer_compositor;

   localparam int NL = 4;
   localparam int CW = 13;

   typedef struct {
      logic [31:0] pix;
      logic        sof;
      logic        eol;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stream_en = 1'b0;

   logic [CW-1:0]    frm_w_v, frm_h_v, bgx_v, bgy_v, bgw_v, bgh_v;
   logic [31:0]      bgc_v;
   logic [NL-1:0]    en_v;
   logic [NL*CW-1:0] lx_v, ly_v, lw_v, lh_v, qx_v, qy_v;
   logic [NL*32-1:0] pix_v;
   logic             out_valid, out_sof, out_eol;
   logic [31:0]      out_pix;

   int fw, fh, bx, by, bw, bh;
   logic [31:0] bgc;
   int lx[NL], ly[NL], lw[NL], lh[NL], sa[NL];
   bit en[NL];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   function automatic logic [31:0] srcpix(int i, int qx, int qy);
      return {8'(sa[i]), 8'(qx*3 + i*40), 8'(qy*7 + i*11), 8'(qx ^ (qy*4))};
   endfunction

   always_comb begin
      frm_w_v = CW'(fw); frm_h_v = CW'(fh);
      bgx_v = CW'(bx); bgy_v = CW'(by); bgw_v = CW'(bw); bgh_v = CW'(bh);
      bgc_v = bgc;
      for (int i = 0; i < NL; i++) begin
         en_v[i] = en[i];
         lx_v[i*CW +: CW] = CW'(lx[i]);
         ly_v[i*CW +: CW] = CW'(ly[i]);
         lw_v[i*CW +: CW] = CW'(lw[i]);
         lh_v[i*CW +: CW] = CW'(lh[i]);
         pix_v[i*32 +: 32] = srcpix(i, int'(qx_v[i*CW +: CW]), int'(qy_v[i*CW +: CW]));
      end
   end

   layer_compositor dut (
      .clk(clk), .rst_n(rst_n), .stream_en(stream_en),
      .frm_w(frm_w_v), .frm_h(frm_h_v),
      .bg_x(bgx_v), .bg_y(bgy_v), .bg_w(bgw_v), .bg_h(bgh_v), .bg_color(bgc_v),
      .lyr_en(en_v), .lyr_x(lx_v), .lyr_y(ly_v), .lyr_w(lw_v), .lyr_h(lh_v),
      .lyr_qx(qx_v), .lyr_qy(qy_v), .lyr_pix(pix_v),
      .out_valid(out_valid), .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
   );

   function automatic int clampi(int v, int lo, int hi);
      return (v < lo) ? lo : ((v > hi) ? hi : v);
   endfunction

   function automatic int bl(int d, int s, int a);
      return (d*(255-a) + s*a + 127) / 255;
   endfunction

   // driver side of the scoreboard: expected frame from the requirements
   task automatic push_frame(string tag);
      int w, h;
      w = clampi(fw, 4, 8190);                          // R1
      h = clampi(fh, 4, 8190);
      for (int y = 0; y < h; y++) begin
         for (int x = 0; x < w; x++) begin
            exp_t e;
            int da, d2, d1, d0;
            logic [31:0] dst;
            dst = (x >= bx && x < bx+bw && y >= by && y < by+bh) ? bgc : 32'h0; // R3
            for (int i = 0; i < NL; i++) begin        // R5 order
               int cx, cy;
               cx = (lx[i] > w-1) ? w-1 : lx[i];     // R9
               cy = (ly[i] > h-1) ? h-1 : ly[i];
               if (en[i] && x >= cx && x < cx+lw[i] && y >= cy && y < cy+lh[i]) begin
                  logic [31:0] s;
                  int a;
                  s = srcpix(i, x-cx, y-cy);            // R11
                  a = int'(s[31:24]);
                  da = bl(int'(dst[31:24]), 255, a);     // R4
                  d2 = bl(int'(dst[23:16]), int'(s[23:16]), a);
                  d1 = bl(int'(dst[15:8]),  int'(s[15:8]),  a);
                  d0 = bl(int'(dst[7:0]),   int'(s[7:0]),   a);
                  dst = {8'(da), 8'(d2), 8'(d1), 8'(d0)};
               end
            end
            e.pix = dst;
            e.sof = (x == 0 && y == 0);
            e.eol = (x == w-1);
            e.tag = tag;
            q.push_back(e);
         end
      end
   endtask

   task automatic run_frame(string tag, int mid_at, int new_lx0, int pause_at);
      int total;
      total = clampi(fw, 4, 8190) * clampi(fh, 4, 8190);
      push_frame(tag);
      @(negedge clk);
      stream_en = 1'b1;
      for (int n = 0; n < total; n++) begin
         if (n == mid_at) lx[0] = new_lx0;           // R10 mid-frame change
         if (n == pause_at) begin                    // R12 hold
            stream_en = 1'b0;
            repeat (8) @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
               fails++;
               $display("FAIL R12 paused valid got %b exp 0", out_valid);
            end
            stream_en = 1'b1;
         end
         @(negedge clk);
      end
      stream_en = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL R2 extra pixel got %h exp none", out_pix);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (out_pix !== e.pix || out_sof !== e.sof || out_eol !== e.eol) begin
               fails++;
               $display("FAIL %s pix/sof/eol got %h/%b/%b exp %h/%b/%b",
                        e.tag, out_pix, out_sof, out_eol, e.pix, e.sof, e.eol);
            end
         end
      end
   end

   task automatic clear_layers();
      for (int i = 0; i < NL; i++) begin
         en[i] = 0; lx[i] = 0; ly[i] = 0; lw[i] = 0; lh[i] = 0; sa[i] = 0;
      end
   endtask

   task automatic set_layer(int i, bit e, int x, int y, int w, int h, int a);
      en[i] = e; lx[i] = x; ly[i] = y; lw[i] = w; lh[i] = h; sa[i] = a;
   endtask

   initial begin
      fw = 16; fh = 8; bx = 0; by = 0; bw = 16; bh = 8; bgc = 32'hFF000000;
      clear_layers();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_eol !== 1'b0) begin
         fails++;
         $display("FAIL R2 reset outputs got %b%b%b exp 000", out_valid, out_sof, out_eol);
      end

      // background rectangle only
      bx = 3; by = 2; bw = 10; bh = 5; bgc = 32'hC0336699;
      run_frame("R3", -1, 0, -1);

      // four overlapping layers, one reaching past the frame edge
      bx = 0; by = 0; bw = 16; bh = 8; bgc = 32'hFF102030;
      set_layer(0, 1, 1, 1, 6, 4, 8'h80);
      set_layer(1, 1, 4, 2, 7, 5, 8'h40);
      set_layer(2, 1, 8, 0, 5, 8, 8'hC0);
      set_layer(3, 1, 10, 5, 9, 6, 8'hFF);
      run_frame("R4 R5 R8 R11", -1, 0, -1);

      // layer 1 alone, opaque: the raster-op path must pass it untouched
      clear_layers();
      set_layer(1, 1, 2, 3, 5, 3, 8'hFF);
      run_frame("R6", -1, 0, -1);

      // disabled opaque layers must not show
      clear_layers();
      set_layer(0, 1, 0, 0, 9, 6, 8'h90);
      set_layer(1, 0, 2, 1, 8, 6, 8'hFF);
      set_layer(2, 0, 5, 2, 8, 5, 8'hFF);
      set_layer(3, 1, 6, 3, 8, 5, 8'h60);
      run_frame("R7", -1, 0, -1);

      // placement beyond the frame is clamped
      clear_layers();
      set_layer(0, 1, 40, 100, 3, 3, 8'hFF);
      run_frame("R9", -1, 0, -1);

      // frame below the minimum size
      clear_layers();
      fw = 2; fh = 3; bw = 4; bh = 4; bgc = 32'h80FF0000;
      set_layer(2, 1, 1, 1, 2, 2, 8'hA0);
      run_frame("R1", -1, 0, -1);

      // mid-frame move of layer 0 applies from the next frame
      clear_layers();
      fw = 16; fh = 8; bw = 16; bh = 8; bgc = 32'hFF000000;
      set_layer(0, 1, 0, 0, 4, 4, 8'hFF);
      run_frame("R10", 40, 8, -1);
      run_frame("R10", -1, 0, -1);

      // stall in the middle of a frame
      set_layer(3, 1, 3, 2, 6, 4, 8'h70);
      run_frame("R12", -1, 0, 50);

      // frame above the maximum width
      clear_layers();
      fw = 8191; fh = 1; bw = 8190; bh = 4; bgc = 32'hFF000000;
      set_layer(3, 1, 8191, 2, 4, 4, 8'hFF);
      run_frame("R1 R9", -1, 0, -1);

      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL R2 missing pixels got %0d left exp 0", q.size());
      end
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog got timeout exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule